// File: doc/BRIEF.md
# Segmented Memory Access Unit

This block turns a segment selector and a 16-bit offset into a 20-bit physical byte address, the way a real-mode x86-style processor forms addresses, and then carries out the access over a byte-wide synchronous memory port. It keeps one cached 20-bit base for each of four segments. A segment base is reloaded whenever its segment register is written, and that includes a far jump that loads the code segment. A requester issues byte or 16-bit word reads, writes and read-modify-write reads, and waits for a one-cycle `done` pulse.

A word always moves as two byte transfers, low byte first, and the low byte sits at the lower address of the pair. When the word would run past offset 0xFFFF, its high byte is taken from offset 0 of the same segment. When it would run past physical address 0xFFFFF, the high byte comes from physical address 0. A read-modify-write whose word is split keeps both byte addresses in a holding register, and a later commit writes the modified word back to exactly those two bytes. A saved low address of zero means "nothing pending". This marker is safe because a split word can never have its low byte at address 0.

Top module: `seg_mem_unit`

## Requirements
- R1: Writing value V to a segment register sets that segment's base to V shifted left by 4. The new base is used by every request accepted on a later clock edge.
- R2: The physical address of the first (low) byte is the segment base plus the zero-extended offset, truncated to 20 bits.
- R3: Selector encoding is 0 = ES, 1 = CS, 2 = SS, 3 = DS. Each selector uses its own cached base.
- R4: After reset, `busy` and `done` are low. The CS base is 0xFFFF0 and the ES, SS and DS bases are 0, so a CS access at offset 0 goes to 0xFFFF0.
- R5: A byte access makes exactly one memory transfer. `done` is high on the second clock edge after acceptance, and `rdata` then holds the byte in bits 7:0 with bits 15:8 equal to zero.
- R6: A word access makes two transfers, low byte first at the computed address and high byte second. Bits 7:0 of the word go to the lower address. `done` is high on the third edge after acceptance.
- R7: A word access at offset 0xFFFF takes its high byte from offset 0x0000 of the same segment, not from the next linear byte.
- R8: A word access whose low byte is at physical address 0xFFFFF takes its high byte from physical address 0x00000.
- R9: A split-word read-modify-write (kind 2) returns the old word and saves both byte addresses. A following commit writes `commit_data` bits 7:0 to the saved low address and bits 15:8 to the saved high address, and `done` is high on the third edge after the commit.
- R10: A commit with nothing pending is ignored: no memory transfer, and `busy` stays low. Nothing is pending after reset, after a commit has been taken, or after a read-modify-write whose word was not split.
- R11: A request presented while `busy` is high is ignored and adds no memory transfer.
- R12: A request accepted on the same edge as a write to its segment register uses the base from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr_en | input | 1 | Write a segment register this cycle |
| seg_wr_sel | input | 2 | Segment selector being written |
| seg_wr_val | input | 16 | New segment register value |
| req_valid | input | 1 | Access request, taken when not busy |
| req_sel | input | 2 | Segment selector of the request |
| req_off | input | 16 | Offset within the segment |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_kind | input | 2 | 0 = read, 1 = write, 2 = read-modify-write read |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| commit_valid | input | 1 | Write back the pending split word |
| commit_data | input | 16 | Modified word to write back |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid while done is high |
| mem_en | output | 1 | Memory transfer this cycle |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, one cycle after mem_en |

## Verification
Acceptance happens on the edge where `req_valid` or `commit_valid` is high and `busy` is low. `done` is due one falling edge after the first following edge for a byte, and one falling edge later for a word or a commit, because the memory returns each byte a cycle after its transfer. Every scenario task releases its request at a falling edge and then counts falling edges until `done`. It compares that count with the expected latency, and it reads `rdata` at that same falling edge. The bench keeps a log of every memory transfer address, taken at the rising edge, together with its own byte store. With these, split ordering, wrap targets and ignored requests are all checked by address and by transfer count.

// File: rtl/seg_pkg.sv
// Shared types for the segmented memory access unit.
// Assumes a two-bit selector space holding exactly four segments.
package seg_pkg;

    typedef enum logic [1:0] {
        SEL_ES = 2'd0,
        SEL_CS = 2'd1,
        SEL_SS = 2'd2,
        SEL_DS = 2'd3
    } seg_sel_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_RMW   = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_LO   = 2'd1,
        XS_HI   = 2'd2,
        XS_FIN  = 2'd3
    } xfer_state_e;

endpackage

// File: rtl/seg_base_cache.sv
// Holds one cached physical base per segment, each being the segment
// register value shifted left by SHIFT bits. The code segment resets to
// CS_RESET and every other segment resets to zero. A write takes effect on
// the clock edge, so a read in the same cycle still returns the old base.
module seg_base_cache #(
    parameter int OFF_W    = 16,
    parameter int SHIFT    = 4,
    parameter int NUM_SEG  = 4,
    parameter int CS_IDX   = 1,
    parameter logic [OFF_W-1:0] CS_RESET = '1,
    localparam int PA_W    = OFF_W + SHIFT,
    localparam int SEL_W   = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [OFF_W-1:0] wr_val,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [PA_W-1:0]  rd_base
);

    logic [PA_W-1:0] base_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        localparam logic [PA_W-1:0] RST_BASE =
            (g == CS_IDX) ? {CS_RESET, {SHIFT{1'b0}}} : '0;

        // Reload this segment's base when its register is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= RST_BASE;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                base_q[g] <= {wr_val, {SHIFT{1'b0}}};
            end
        end
    end

    // Select the base of the requested segment.
    always_comb begin
        rd_base = base_q[rd_sel];
    end

endmodule

// File: rtl/seg_addr_gen.sv
// Forms the two byte addresses of an access from a segment base and an
// offset. The high byte normally follows the low byte. At the last offset
// it wraps to offset zero of the same segment, and at the top of physical
// memory it wraps to address zero. Purely combinational.
module seg_addr_gen #(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = OFF_W + SHIFT
) (
    input  logic [PA_W-1:0]  base,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  lo_addr,
    output logic [PA_W-1:0]  hi_addr,
    output logic             split
);

    logic seg_end;
    logic phys_end;

    // Low byte address and both wrap conditions.
    always_comb begin
        lo_addr  = base + PA_W'(off);
        seg_end  = (off == {OFF_W{1'b1}});
        phys_end = (lo_addr == {PA_W{1'b1}});
        split    = seg_end || phys_end;
    end

    // High byte address, following the applicable wrap rule.
    always_comb begin
        if (seg_end) begin
            hi_addr = base;
        end else if (phys_end) begin
            hi_addr = '0;
        end else begin
            hi_addr = lo_addr + PA_W'(1);
        end
    end

endmodule

// File: rtl/seg_rmw_hold.sv
// Keeps the two byte addresses of a split-word read-modify-write until the
// result is committed. A saved low address of zero stands for "nothing
// pending", since a split word never has its low byte at address zero.
module seg_rmw_hold #(
    parameter int PA_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save,
    input  logic [PA_W-1:0] save_lo,
    input  logic [PA_W-1:0] save_hi,
    input  logic            clear,
    output logic            pend_valid,
    output logic [PA_W-1:0] pend_lo,
    output logic [PA_W-1:0] pend_hi
);

    logic [PA_W-1:0] lo_q;
    logic [PA_W-1:0] hi_q;

    // Capture on save and drop back to the empty marker on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (save) begin
            lo_q <= save_lo;
            hi_q <= save_hi;
        end else if (clear) begin
            lo_q <= '0;
        end
    end

    // Expose the pending pair and its validity.
    always_comb begin
        pend_valid = (lo_q != '0);
        pend_lo    = lo_q;
        pend_hi    = hi_q;
    end

endmodule

// File: rtl/seg_xfer_ctrl.sv
// Sequences byte transfers on a synchronous byte-wide memory port. A byte
// access is one transfer; a word is two, low byte first. Read data comes
// back one cycle after its transfer. A commit of a pending split word is
// taken ahead of a new request and is ignored if nothing is pending.
// Assumes mem_rdata is registered by the memory.
module seg_xfer_ctrl
    import seg_pkg::*;
#(
    parameter int PA_W = 20,
    parameter int DW   = 8,
    localparam int WW  = 2 * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_kind,
    input  logic            req_word,
    input  logic [WW-1:0]   req_wdata,
    input  logic [PA_W-1:0] lo_addr,
    input  logic [PA_W-1:0] hi_addr,
    input  logic            split,
    input  logic            commit_valid,
    input  logic [WW-1:0]   commit_data,
    input  logic            pend_valid,
    input  logic [PA_W-1:0] pend_lo,
    input  logic [PA_W-1:0] pend_hi,
    output logic            save_pend,
    output logic [PA_W-1:0] save_lo,
    output logic [PA_W-1:0] save_hi,
    output logic            clear_pend,
    output logic            mem_en,
    output logic            mem_we,
    output logic [PA_W-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            done,
    output logic [WW-1:0]   rdata
);

    xfer_state_e     state_q, state_d;
    acc_kind_e       kind_q;
    logic            word_q;
    logic            split_q;
    logic [PA_W-1:0] lo_q;
    logic [PA_W-1:0] hi_q;
    logic [WW-1:0]   wdata_q;
    logic [DW-1:0]   lo_byte_q;
    logic            take_commit;
    logic            take_req;

    // Decide what, if anything, is accepted this cycle.
    always_comb begin
        take_commit = (state_q == XS_IDLE) && commit_valid && pend_valid;
        take_req    = (state_q == XS_IDLE) && !take_commit && req_valid;
        clear_pend  = take_commit;
    end

    // Next-state logic of the transfer sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (take_commit || take_req) state_d = XS_LO;
            XS_LO:   state_d = word_q ? XS_HI : XS_FIN;
            XS_HI:   state_d = XS_FIN;
            XS_FIN:  state_d = XS_IDLE;
            default: state_d = XS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // Latch the operation at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= ACC_READ;
            word_q  <= 1'b0;
            split_q <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
            wdata_q <= '0;
        end else if (take_commit) begin
            kind_q  <= ACC_WRITE;
            word_q  <= 1'b1;
            split_q <= 1'b0;
            lo_q    <= pend_lo;
            hi_q    <= pend_hi;
            wdata_q <= commit_data;
        end else if (take_req) begin
            kind_q  <= acc_kind_e'(req_kind);
            word_q  <= req_word;
            split_q <= split;
            lo_q    <= lo_addr;
            hi_q    <= hi_addr;
            wdata_q <= req_wdata;
        end
    end

    // Hold the low byte of a word while the high byte is fetched.
    always_ff @(posedge clk) begin
        if (!rst_n)                lo_byte_q <= '0;
        else if (state_q == XS_HI) lo_byte_q <= mem_rdata;
    end

    // Drive the memory port during the transfer states.
    always_comb begin
        mem_en    = (state_q == XS_LO) || (state_q == XS_HI);
        mem_we    = mem_en && (kind_q == ACC_WRITE);
        mem_addr  = (state_q == XS_HI) ? hi_q : lo_q;
        mem_wdata = (state_q == XS_HI) ? wdata_q[WW-1:DW] : wdata_q[DW-1:0];
    end

    // Completion, read data and the pending-address capture.
    always_comb begin
        busy      = (state_q != XS_IDLE);
        done      = (state_q == XS_FIN);
        rdata     = '0;
        if (done && (kind_q != ACC_WRITE)) begin
            rdata = word_q ? {mem_rdata, lo_byte_q} : {{DW{1'b0}}, mem_rdata};
        end
        save_pend = done && (kind_q == ACC_RMW) && word_q && split_q;
        save_lo   = lo_q;
        save_hi   = hi_q;
    end

endmodule

// File: rtl/seg_mem_unit.sv
// Top of the segmented memory access unit. It turns selector and offset
// into physical byte addresses from the cached segment bases and runs
// byte or split word transfers on a byte-wide synchronous memory.
// Assumes requests are only presented when the requester wants them taken.
module seg_mem_unit
    import seg_pkg::*;
#(
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 4,
    parameter int DW      = 8,
    localparam int PA_W   = OFF_W + SHIFT,
    localparam int WW     = 2 * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_wr_en,
    input  logic [1:0]       seg_wr_sel,
    input  logic [OFF_W-1:0] seg_wr_val,
    input  logic             req_valid,
    input  logic [1:0]       req_sel,
    input  logic [OFF_W-1:0] req_off,
    input  logic             req_word,
    input  logic [1:0]       req_kind,
    input  logic [WW-1:0]    req_wdata,
    input  logic             commit_valid,
    input  logic [WW-1:0]    commit_data,
    output logic             busy,
    output logic             done,
    output logic [WW-1:0]    rdata,
    output logic             mem_en,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata
);

    logic [PA_W-1:0] base;
    logic [PA_W-1:0] lo_addr;
    logic [PA_W-1:0] hi_addr;
    logic            split;
    logic            save_pend;
    logic [PA_W-1:0] save_lo;
    logic [PA_W-1:0] save_hi;
    logic            clear_pend;
    logic            pend_valid;
    logic [PA_W-1:0] pend_lo;
    logic [PA_W-1:0] pend_hi;

    seg_base_cache #(
        .OFF_W   (OFF_W),
        .SHIFT   (SHIFT),
        .NUM_SEG (4),
        .CS_IDX  (int'(SEL_CS))
    ) u_bases (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_val  (seg_wr_val),
        .rd_sel  (req_sel),
        .rd_base (base)
    );

    seg_addr_gen #(
        .OFF_W (OFF_W),
        .SHIFT (SHIFT)
    ) u_agen (
        .base    (base),
        .off     (req_off),
        .lo_addr (lo_addr),
        .hi_addr (hi_addr),
        .split   (split)
    );

    seg_rmw_hold #(
        .PA_W (PA_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .save       (save_pend),
        .save_lo    (save_lo),
        .save_hi    (save_hi),
        .clear      (clear_pend),
        .pend_valid (pend_valid),
        .pend_lo    (pend_lo),
        .pend_hi    (pend_hi)
    );

    seg_xfer_ctrl #(
        .PA_W (PA_W),
        .DW   (DW)
    ) u_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_kind     (req_kind),
        .req_word     (req_word),
        .req_wdata    (req_wdata),
        .lo_addr      (lo_addr),
        .hi_addr      (hi_addr),
        .split        (split),
        .commit_valid (commit_valid),
        .commit_data  (commit_data),
        .pend_valid   (pend_valid),
        .pend_lo      (pend_lo),
        .pend_hi      (pend_hi),
        .save_pend    (save_pend),
        .save_lo      (save_lo),
        .save_hi      (save_hi),
        .clear_pend   (clear_pend),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .busy         (busy),
        .done         (done),
        .rdata        (rdata)
    );

endmodule

// File: rtl/seg_mem_unit_chk.sv
// Temporal checks on the ports of the segmented memory access unit,
// attached to every instance by the bind at the end of this file.
module seg_mem_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        commit_valid,
    input logic        req_word,
    input logic        busy,
    input logic        done,
    input logic        mem_en,
    input logic [15:0] rdata
);

    // R4
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));

    // R11
    no_xfer_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);

    // R5
    done_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_en) && busy));

    // R11
    busy_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(req_valid) || $past(commit_valid)));

    // R6
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    // R5
    byte_first_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !req_word && !commit_valid) |=> mem_en);

endmodule

bind seg_mem_unit seg_mem_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .commit_valid (commit_valid),
    .req_word     (req_word),
    .busy         (busy),
    .done         (done),
    .mem_en       (mem_en),
    .rdata        (rdata)
);

// File: tb/sim_seg_mem_unit.sv
module sim_seg_mem_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_val = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_sel = '0;
    logic [15:0] req_off = '0;
    logic        req_word = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_wdata = '0;
    logic        commit_valid = 1'b0;
    logic [15:0] commit_data = '0;
    logic        busy, done;
    logic [15:0] rdata;
    logic        mem_en, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [7:0]  store [logic [19:0]];
    logic [19:0] log_a [8];
    int          log_n = 0;

    always #5 clk = ~clk;

    seg_mem_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_val(seg_wr_val),
        .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off),
        .req_word(req_word), .req_kind(req_kind), .req_wdata(req_wdata),
        .commit_valid(commit_valid), .commit_data(commit_data),
        .busy(busy), .done(done), .rdata(rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] fill(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] peek(input logic [19:0] a);
        return store.exists(a) ? store[a] : fill(a);
    endfunction

    // Byte memory with registered read data, plus a transfer address log.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) store[mem_addr] = mem_wdata;
            else        mem_rdata <= peek(mem_addr);
            if (log_n < 8) log_a[log_n] = mem_addr;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_seg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_val = val;
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    // Issue one request and wait for done; returns data and latency.
    task automatic do_op(input logic [1:0] sel, input logic [15:0] off, input bit word,
                         input logic [1:0] kind, input logic [15:0] wd,
                         output logic [15:0] rd, output int lat);
        @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_sel = sel; req_off = off;
        req_word = word; req_kind = kind; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        rd = rdata;
        @(negedge clk);
    endtask

    task automatic do_commit(input logic [15:0] d, output int lat, output bit saw_busy);
        @(negedge clk);
        log_n = 0;
        commit_valid = 1'b1; commit_data = d;
        @(negedge clk);
        commit_valid = 1'b0;
        saw_busy = busy;
        lat = 0;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] rd; int lat;
        chk(!busy && !done, "R4 idle after reset", {busy, done}, 0);
        do_op(2'd1, 16'h0000, 1'b0, 2'd0, 16'h0, rd, lat);
        chk(log_a[0] == 20'hFFFF0, "R4 CS reset base", log_a[0], 20'hFFFF0);
        do_op(2'd3, 16'h0040, 1'b0, 2'd0, 16'h0, rd, lat);
        chk(log_a[0] == 20'h00040, "R4 DS reset base", log_a[0], 20'h00040);
    endtask

    task automatic t_byte();
        logic [15:0] rd; int lat;
        set_seg(2'd3, 16'h1234);
        do_op(2'd3, 16'h0010, 1'b0, 2'd0, 16'h0, rd, lat);
        chk(log_a[0] == 20'h12350, "R1 R2 byte address", log_a[0], 20'h12350);
        chk(log_n == 1 && lat == 1, "R5 one transfer, latency", {log_n[15:0], lat[15:0]}, 32'h0001_0001);
        chk(rd == {8'h00, fill(20'h12350)}, "R5 byte data", rd, {8'h00, fill(20'h12350)});
    endtask

    task automatic t_selectors();
        logic [15:0] rd; int lat;
        set_seg(2'd0, 16'h1000);
        set_seg(2'd1, 16'h3000);
        set_seg(2'd2, 16'h2000);
        set_seg(2'd3, 16'h4000);
        do_op(2'd0, 16'h0001, 1'b0, 2'd0, 16'h0, rd, lat);
        chk(log_a[0] == 20'h10001, "R3 ES", log_a[0], 20'h10001);
        do_op(2'd1, 16'h0002, 1'b0, 2'd0, 16'h0, rd, lat);
        chk(log_a[0] == 20'h30002, "R3 CS far load", log_a[0], 20'h30002);
        do_op(2'd2, 16'h0003, 1'b0, 2'd0, 16'h0, rd, lat);
        chk(log_a[0] == 20'h20003, "R3 SS", log_a[0], 20'h20003);
        do_op(2'd3, 16'h0004, 1'b0, 2'd0, 16'h0, rd, lat);
        chk(log_a[0] == 20'h40004, "R3 DS", log_a[0], 20'h40004);
    endtask

    task automatic t_word();
        logic [15:0] rd; int lat;
        set_seg(2'd3, 16'h1234);
        do_op(2'd3, 16'h0100, 1'b1, 2'd1, 16'hBEEF, rd, lat);
        chk(log_n == 2 && log_a[0] == 20'h12440 && log_a[1] == 20'h12441,
            "R6 word order", log_a[1], 20'h12441);
        chk(peek(20'h12440) == 8'hEF && peek(20'h12441) == 8'hBE, "R6 little-endian",
            {peek(20'h12441), peek(20'h12440)}, 16'hBEEF);
        chk(lat == 2, "R6 write latency", lat, 2);
        do_op(2'd3, 16'h0100, 1'b1, 2'd0, 16'h0, rd, lat);
        chk(rd == 16'hBEEF && lat == 2, "R6 read back", rd, 16'hBEEF);
    endtask

    task automatic t_trunc();
        logic [15:0] rd; int lat;
        set_seg(2'd2, 16'hFFFF);
        do_op(2'd2, 16'h0020, 1'b0, 2'd0, 16'h0, rd, lat);
        chk(log_a[0] == 20'h00010, "R2 20-bit truncation", log_a[0], 20'h00010);
    endtask

    task automatic t_seg_wrap();
        logic [15:0] rd; int lat;
        logic [15:0] exp;
        set_seg(2'd3, 16'h2000);
        do_op(2'd3, 16'hFFFF, 1'b1, 2'd0, 16'h0, rd, lat);
        exp = {peek(20'h20000), peek(20'h2FFFF)};
        chk(log_a[0] == 20'h2FFFF && log_a[1] == 20'h20000, "R7 wrap addresses", log_a[1], 20'h20000);
        chk(rd == exp, "R7 wrap read", rd, exp);
        do_op(2'd3, 16'hFFFF, 1'b1, 2'd1, 16'hC3A1, rd, lat);
        chk(peek(20'h2FFFF) == 8'hA1 && peek(20'h20000) == 8'hC3 && peek(20'h30000) == fill(20'h30000),
            "R7 wrap write", {peek(20'h20000), peek(20'h2FFFF)}, 16'hC3A1);
    endtask

    task automatic t_phys_wrap();
        logic [15:0] rd; int lat;
        set_seg(2'd0, 16'hFFFF);
        do_op(2'd0, 16'h000F, 1'b1, 2'd1, 16'h1357, rd, lat);
        chk(log_a[0] == 20'hFFFFF && log_a[1] == 20'h00000, "R8 wrap addresses", log_a[1], 20'h0);
        chk(peek(20'hFFFFF) == 8'h57 && peek(20'h00000) == 8'h13, "R8 wrap bytes",
            {peek(20'h00000), peek(20'hFFFFF)}, 16'h1357);
    endtask

    task automatic t_rmw();
        logic [15:0] rd, exp; int lat; bit sb;
        do_commit(16'h1111, lat, sb);
        chk(!sb && log_n == 0, "R10 commit after reset ignored", log_n, 0);
        set_seg(2'd2, 16'h3000);
        exp = {peek(20'h30000), peek(20'h3FFFF)};
        do_op(2'd2, 16'hFFFF, 1'b1, 2'd2, 16'h0, rd, lat);
        chk(rd == exp, "R9 rmw old value", rd, exp);
        do_commit(16'hA55A, lat, sb);
        chk(log_n == 2 && log_a[0] == 20'h3FFFF && log_a[1] == 20'h30000, "R9 commit addresses",
            log_a[0], 20'h3FFFF);
        chk(peek(20'h3FFFF) == 8'h5A && peek(20'h30000) == 8'hA5 && lat == 2, "R9 commit data",
            {peek(20'h30000), peek(20'h3FFFF)}, 16'hA55A);
        do_commit(16'h2222, lat, sb);
        chk(!sb && log_n == 0 && peek(20'h3FFFF) == 8'h5A, "R10 second commit ignored", log_n, 0);
        do_op(2'd2, 16'h0200, 1'b1, 2'd2, 16'h0, rd, lat);
        do_commit(16'h3333, lat, sb);
        chk(!sb && log_n == 0 && peek(20'h30200) == fill(20'h30200), "R10 unsplit rmw leaves nothing",
            log_n, 0);
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_sel = 2'd3; req_off = 16'h0500; req_word = 1'b1; req_kind = 2'd0;
        @(negedge clk);
        req_off = 16'h0700;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(log_n == 2, "R11 request while busy ignored", log_n, 2);
    endtask

    task automatic t_same_cycle();
        logic [15:0] rd; int lat;
        set_seg(2'd3, 16'h4000);
        @(negedge clk);
        log_n = 0;
        seg_wr_en = 1'b1; seg_wr_sel = 2'd3; seg_wr_val = 16'h5000;
        req_valid = 1'b1; req_sel = 2'd3; req_off = 16'h0000; req_word = 1'b0; req_kind = 2'd0;
        @(negedge clk);
        seg_wr_en = 1'b0; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(log_a[0] == 20'h40000, "R12 old base used", log_a[0], 20'h40000);
        do_op(2'd3, 16'h0000, 1'b0, 2'd0, 16'h0, rd, lat);
        chk(log_a[0] == 20'h50000, "R1 new base afterwards", log_a[0], 20'h50000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte();
        t_selectors();
        t_word();
        t_trunc();
        t_seg_wrap();
        t_phys_wrap();
        t_rmw();
        t_busy_ignore();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule